// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Slave with Broadcast Reset

This block is the serial front end of a programmable reference device. It samples the two bus lines, SCL and SDA, with a fast system clock. It finds the START and STOP conditions and frames each byte with its acknowledge slot. It accepts write transfers that are addressed to it. The 7-bit device address is a fixed 6-bit prefix (`111010` by default) followed by the level of one strap pin. The address 74h is therefore used with the strap low, and 75h with the strap high.

Each data byte that is written to the device goes to the register layer as an 8-bit value together with a one-cycle valid strobe. The register layer gives the byte its meaning.

The block also reacts to two bus-wide messages:
- A broadcast address of 00h followed by a 06h data byte produces a one-cycle soft reset pulse.
- A first byte of the form 00001xxx marks a high-speed master code. This byte is not acknowledged, and it sets a high-speed flag that stays set until the next STOP.

The block never drives SCL. On SDA it only requests a pull-down, which an open-drain pad turns into a low level.

Top module: `i2c_refslave`

## Requirements
- R1: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. Both are judged on the synchronised line levels. A START in any state, including in the middle of a transfer, restarts address reception without a STOP first.
- R2: A first byte whose upper seven bits equal `111010` followed by `addr_strap`, and whose last bit is 0 (write), is acknowledged. The block holds `sda_pull` high (SDA low) during the ninth SCL pulse.
- R3: A first byte whose last bit is 1 (read), or whose upper seven bits match no accepted address, gets no acknowledge. Every byte after it is then ignored, with no acknowledge and no strobe, until the next START.
- R4: Each byte written after an acknowledged device address is shifted in MSB first. It is presented on `byte_data` with `byte_valid` high for exactly one clock, and it is acknowledged.
- R5: A first byte of 00h followed by a data byte of 06h raises `soft_rst_pulse` for exactly one clock. Both bytes are acknowledged. Any other second byte gives no pulse. Neither byte appears on `byte_valid`.
- R6: A first byte whose upper five bits are `00001` is not acknowledged and sets `hs_mode`. `hs_mode` stays high through repeated STARTs and clears on the next STOP.
- R7: `sda_pull` changes only while the synchronised SCL is low, so the slave never makes a START or STOP on the bus.
- R8: After reset `sda_pull`, `byte_valid`, `soft_rst_pulse` and `hs_mode` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap | input | 1 | Strapped least significant address bit |
| sda_pull | output | 1 | 1 requests the pad to pull SDA low |
| byte_data | output | 8 | Last received data byte |
| byte_valid | output | 1 | One-cycle strobe for a new `byte_data` |
| soft_rst_pulse | output | 1 | One-cycle broadcast reset pulse |
| hs_mode | output | 1 | High-speed master code seen since the last STOP |

## Verification
A wrong bit counter or byte-kind state shows up first in the acknowledge slot of the same byte. It appears either as a missing pull-down or as a pull-down in the wrong position, and the bench samples every ninth clock pulse. A shift error shows up in the value on `byte_data` at the strobe, which comes within a few system clocks after the eighth SCL rise. A wrong decision after a refused address, or a missed repeated START, shows up within one byte as acknowledges or strobes where none are expected. A high-speed flag that sticks is caught at the first STOP.

// File: rtl/i2c_refslave.sv
module i2c_refslave #(
  parameter logic [5:0] ADDR_PREFIX   = 6'b111010,
  parameter logic [7:0] GC_RESET_CODE = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_strap,
  output logic       sda_pull,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       soft_rst_pulse,
  output logic       hs_mode
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACK, S_SKIP} state_t;
  typedef enum logic [1:0] {K_ADDR, K_DATA, K_GC} kind_t;

  logic       scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [6:0] shreg;
  logic [3:0] cnt;
  logic       ack_en, go_on;
  state_t     state;
  kind_t      kind;

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] full = {shreg, sda_s};
  wire own_hit   = (full[7:1] == {ADDR_PREFIX, addr_strap}) && !full[0];
  wire gc_hit    = (full == 8'h00);
  wire mc_hit    = (full[7:3] == 5'b00001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q} <= 3'b111;
      {sda_m, sda_s, sda_q} <= 3'b111;
    end else begin
      {scl_m, scl_s, scl_q} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_q} <= {sda_i, sda_m, sda_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      kind           <= K_ADDR;
      shreg          <= '0;
      cnt            <= '0;
      ack_en         <= 1'b0;
      go_on          <= 1'b0;
      sda_pull       <= 1'b0;
      byte_data      <= '0;
      byte_valid     <= 1'b0;
      soft_rst_pulse <= 1'b0;
      hs_mode        <= 1'b0;
    end else begin
      byte_valid     <= 1'b0;
      soft_rst_pulse <= 1'b0;
      if (stop_det) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
        hs_mode  <= 1'b0;
      end else if (start_det) begin
        state    <= S_RECV;
        kind     <= K_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_RECV: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= full[6:0];
              cnt   <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                case (kind)
                  K_ADDR: begin
                    ack_en <= own_hit | gc_hit;
                    go_on  <= own_hit | gc_hit;
                    kind   <= gc_hit ? K_GC : K_DATA;
                    if (mc_hit) hs_mode <= 1'b1;
                  end
                  K_DATA: begin
                    ack_en     <= 1'b1;
                    go_on      <= 1'b1;
                    byte_data  <= full;
                    byte_valid <= 1'b1;
                  end
                  default: begin
                    ack_en         <= 1'b1;
                    go_on          <= 1'b0;
                    soft_rst_pulse <= (full == GC_RESET_CODE);
                  end
                endcase
              end
            end else if (scl_fall && cnt == 4'd8) begin
              state    <= S_ACK;
              sda_pull <= ack_en;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= go_on ? S_RECV : S_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_refslave_chk.sv
module i2c_refslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic sda_pull,
  input logic byte_valid,
  input logic soft_rst_pulse,
  input logic hs_mode
);
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R4
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse); // R5
  AST_RESET_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && soft_rst_pulse)); // R5
  AST_HS_CLEARS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode); // R6
  AST_NO_PULL_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull); // R1
endmodule

bind i2c_refslave i2c_refslave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_pull(sda_pull), .byte_valid(byte_valid),
  .soft_rst_pulse(soft_rst_pulse), .hs_mode(hs_mode)
);

// File: tb/i2c_refslave_tb_top.sv
module i2c_refslave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_pull, byte_valid, soft_rst_pulse, hs_mode;
  logic [7:0] byte_data;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_bad = 0, n_rst = 0;
  logic [7:0] got_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_refslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .byte_data(byte_data),
    .byte_valid(byte_valid), .soft_rst_pulse(soft_rst_pulse), .hs_mode(hs_mode)
  );

  always @(negedge clk) begin
    if (byte_valid) got_q.push_back(byte_data);
    if (soft_rst_pulse) n_rst++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q_wait();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait(); end
    sda_m = 1'b0; q_wait(); scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait(); scl_m = 1'b1; q_wait(); sda_m = 1'b1; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q_wait(); scl_m = 1'b1; q_wait(); q_wait(); scl_m = 1'b0; q_wait();
    end
    sda_m = 1'b1; q_wait(); scl_m = 1'b1; q_wait();
    acked = (sda_line == 1'b0);
    q_wait(); scl_m = 1'b0; q_wait();
  endtask

  function automatic bit exp_addr_ack(logic [7:0] b, logic s);
    return (b[7:1] == {6'b111010, s} && !b[0]) || b == 8'h00;
  endfunction

  function automatic bit exp_own(logic [7:0] b, logic s);
    return b[7:1] == {6'b111010, s} && !b[0];
  endfunction

  task automatic write_xfer(input logic [7:0] a, input int n, input string req);
    bit ak;
    logic [7:0] d;
    bit own;
    own = exp_own(a, strap);
    got_q.delete();
    send_byte(a, ak);
    chk({req, " addr ack"}, ak, exp_addr_ack(a, strap));
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ak);
      chk({req, " data ack"}, ak, own);
      if (own) begin
        chk({req, " strobe count"}, got_q.size(), 1);
        if (got_q.size() > 0) chk({req, " byte value"}, got_q.pop_front(), d);
      end else begin
        chk({req, " no strobe"}, got_q.size(), 0);
      end
      got_q.delete();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit ak;
    logic [7:0] a;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R8 pull", sda_pull, 0); chk("R8 valid", byte_valid, 0);
    chk("R8 rst", soft_rst_pulse, 0); chk("R8 hs", hs_mode, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    strap = 1'b0;
    bus_start(); write_xfer(8'hE8, 3, "R2 R4 strap0"); bus_stop();
    strap = 1'b1;
    bus_start(); write_xfer(8'hEA, 2, "R2 R4 strap1"); bus_stop();
    bus_start(); write_xfer(8'hE8, 2, "R3 wrong strap"); bus_stop();
    bus_start(); write_xfer(8'hEB, 1, "R3 read bit"); bus_stop();

    bus_start(); write_xfer(8'hEA, 1, "R1 first part");
    bus_start(); write_xfer(8'hEA, 2, "R1 repeated start");
    bus_start(); write_xfer(8'h52, 1, "R1 R3 restart to foreign"); bus_stop();

    n_rst = 0; got_q.delete();
    bus_start(); send_byte(8'h00, ak); chk("R5 gc addr ack", ak, 1);
    send_byte(8'h06, ak); chk("R5 gc data ack", ak, 1); bus_stop();
    chk("R5 reset pulse", n_rst, 1); chk("R5 no strobe", got_q.size(), 0);
    n_rst = 0;
    bus_start(); send_byte(8'h00, ak); send_byte(8'h04, ak); bus_stop();
    chk("R5 other code no pulse", n_rst, 0);

    bus_start(); send_byte(8'h0D, ak);
    chk("R6 master code nack", ak, 0); chk("R6 hs set", hs_mode, 1);
    bus_start(); write_xfer(8'hEA, 1, "R6 after restart");
    chk("R6 hs kept", hs_mode, 1);
    bus_stop(); q_wait();
    chk("R6 hs cleared", hs_mode, 0);

    for (int t = 0; t < 20; t++) begin
      strap = 1'($urandom);
      case ($urandom % 3)
        0: a = {6'b111010, strap, 1'b0};
        1: a = {6'b111010, strap, 1'($urandom)};
        default: a = 8'($urandom);
      endcase
      if (a == 8'h00 || a[7:3] == 5'b00001) a = 8'hF0;
      bus_start(); write_xfer(a, 1 + int'($urandom % 3), "R2 R3 R4 random"); bus_stop();
      chk("R7 pull idle", sda_pull, 0);
    end
    summary();
  end
endmodule